// File: doc/BRIEF.md
# Layer Priority Compositor

This block merges, pixel by pixel, the candidates of two scroll planes and of the single winning sprite into one 12-bit output color. Each plane supplies a 2-bit color index and the color it has already looked up. The sprite supplies the same two things plus a 2-bit placement level. The sprite color has already been looked up in the sprite palette bank, which is separate from the plane palettes. A plane-order byte decides which plane lies on top. A background-control byte decides whether the programmed background color or black fills the pixels where no layer is opaque.

The sprite level places the sprite in one of four slots: not drawn, under both planes, between the two planes, or over everything. From top to bottom the stack is: top-level sprite, front plane, middle-level sprite, back plane, bottom-level sprite, background. When the display enable is low, the output is the resolved background color whatever the layers hold. The result is registered, so the output follows its inputs by exactly one clock.

Top module: `layer_compositor`

## Requirements
- R1: While `rst` is high on a clock edge, `pix_rgb` becomes 0x000.
- R2: `pix_rgb` shows the composite of the inputs sampled at the previous rising clock edge (one cycle latency).
- R3: A sprite with level 2'b11 and a nonzero index is output over both planes.
- R4: A sprite with level 2'b00 is never output; the result is what the planes and background give without it.
- R5: A sprite with level 2'b10 and a nonzero index is hidden by an opaque front plane, but shows over an opaque back plane.
- R6: A sprite with level 2'b01 and a nonzero index is hidden by either opaque plane, but shows over the background.
- R7: Bit 7 of `order_reg` selects the front plane: 0 puts plane 1 in front, 1 puts plane 2 in front. The other bits of `order_reg` have no effect.
- R8: A plane pixel with index 2'b00 is transparent, and the layers under it show through.
- R9: A sprite pixel with index 2'b00 is transparent whatever its level.
- R10: The background is `bg_rgb` when `bg_ctrl[7:6]` is 2'b10, and 0x000 (black) for any other value of that field. The low six bits of `bg_ctrl` have no effect.
- R11: When `disp_en` is low, the output is the background of R10, whatever the layers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Display enable; low forces the background |
| pl1_idx | input | 2 | Plane 1 color index (0 = transparent) |
| pl1_rgb | input | 12 | Plane 1 looked-up color |
| pl2_idx | input | 2 | Plane 2 color index (0 = transparent) |
| pl2_rgb | input | 12 | Plane 2 looked-up color |
| order_reg | input | 8 | Plane order byte; bit 7 selects the front plane |
| spr_idx | input | 2 | Sprite color index (0 = transparent) |
| spr_rgb | input | 12 | Sprite color from the sprite palette bank |
| spr_lvl | input | 2 | Sprite level: 00 off, 01 bottom, 10 middle, 11 top |
| bg_ctrl | input | 8 | Background control; bits 7-6 = 10 enable `bg_rgb` |
| bg_rgb | input | 12 | Programmed background color |
| pix_rgb | output | 12 | Registered composite color |

## Verification
The assertions assume that every input is a known value at each rising edge after reset. They also assume that each assertion's condition describes the whole input set of that cycle, so that a check of the top-level sprite needs only the sprite inputs. The bench drives every input away from the clock edge and holds it for a full cycle, and it never leaves a field undriven. Its directed patterns vary the bits that must not matter: the low bits of the order and control bytes, and the colors behind transparent indices. This shows that only the specified fields steer the result.

// File: rtl/layer_compositor_pkg.sv
package layer_compositor_pkg;
  typedef enum logic [1:0] {
    LVL_OFF    = 2'b00,
    LVL_BOTTOM = 2'b01,
    LVL_MIDDLE = 2'b10,
    LVL_TOP    = 2'b11
  } spr_level_e;

  localparam logic [1:0] BG_ON_CODE = 2'b10;
endpackage

// File: rtl/lc_bg_select.sv
module lc_bg_select #(
  parameter int COLOR_W = 12,
  parameter int CTRL_W  = 8
) (
  input  logic [CTRL_W-1:0]  ctrl,
  input  logic [COLOR_W-1:0] prog_rgb,
  output logic [COLOR_W-1:0] bg_out
);
  import layer_compositor_pkg::*;
  localparam int FIELD_LSB = CTRL_W - 2;

  always_comb begin
    if (ctrl[CTRL_W-1:FIELD_LSB] == BG_ON_CODE) bg_out = prog_rgb;
    else                                        bg_out = '0;
  end
endmodule

// File: rtl/lc_plane_order.sv
module lc_plane_order #(
  parameter int COLOR_W = 12,
  parameter int IDX_W   = 2
) (
  input  logic               swap,
  input  logic [IDX_W-1:0]   a_idx,
  input  logic [COLOR_W-1:0] a_rgb,
  input  logic [IDX_W-1:0]   b_idx,
  input  logic [COLOR_W-1:0] b_rgb,
  output logic               front_vis,
  output logic [COLOR_W-1:0] front_rgb,
  output logic               back_vis,
  output logic [COLOR_W-1:0] back_rgb
);
  logic a_vis, b_vis;
  assign a_vis = (a_idx != '0);
  assign b_vis = (b_idx != '0);

  always_comb begin
    if (swap) begin
      front_vis = b_vis; front_rgb = b_rgb;
      back_vis  = a_vis; back_rgb  = a_rgb;
    end else begin
      front_vis = a_vis; front_rgb = a_rgb;
      back_vis  = b_vis; back_rgb  = b_rgb;
    end
  end
endmodule

// File: rtl/lc_layer_stack.sv
module lc_layer_stack #(
  parameter int COLOR_W = 12,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0]   spr_idx,
  input  logic [COLOR_W-1:0] spr_rgb,
  input  logic [1:0]         spr_lvl,
  input  logic               front_vis,
  input  logic [COLOR_W-1:0] front_rgb,
  input  logic               back_vis,
  input  logic [COLOR_W-1:0] back_rgb,
  input  logic [COLOR_W-1:0] bg_rgb,
  output logic [COLOR_W-1:0] mix_rgb
);
  import layer_compositor_pkg::*;
  logic spr_vis;
  spr_level_e lvl;
  assign spr_vis = (spr_idx != '0);
  assign lvl     = spr_level_e'(spr_lvl);

  always_comb begin
    if (spr_vis && lvl == LVL_TOP)         mix_rgb = spr_rgb;
    else if (front_vis)                    mix_rgb = front_rgb;
    else if (spr_vis && lvl == LVL_MIDDLE) mix_rgb = spr_rgb;
    else if (back_vis)                     mix_rgb = back_rgb;
    else if (spr_vis && lvl == LVL_BOTTOM) mix_rgb = spr_rgb;
    else                                   mix_rgb = bg_rgb;
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor #(
  parameter int COLOR_W = 12,
  parameter int IDX_W   = 2,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_en,
  input  logic [IDX_W-1:0]   pl1_idx,
  input  logic [COLOR_W-1:0] pl1_rgb,
  input  logic [IDX_W-1:0]   pl2_idx,
  input  logic [COLOR_W-1:0] pl2_rgb,
  input  logic [REG_W-1:0]   order_reg,
  input  logic [IDX_W-1:0]   spr_idx,
  input  logic [COLOR_W-1:0] spr_rgb,
  input  logic [1:0]         spr_lvl,
  input  logic [REG_W-1:0]   bg_ctrl,
  input  logic [COLOR_W-1:0] bg_rgb,
  output logic [COLOR_W-1:0] pix_rgb
);
  localparam int ORDER_BIT = REG_W - 1;

  logic [COLOR_W-1:0] bg_res, front_rgb, back_rgb, mix_rgb;
  logic               front_vis, back_vis;

  lc_bg_select #(.COLOR_W(COLOR_W), .CTRL_W(REG_W)) u_bg (
    .ctrl(bg_ctrl), .prog_rgb(bg_rgb), .bg_out(bg_res)
  );

  lc_plane_order #(.COLOR_W(COLOR_W), .IDX_W(IDX_W)) u_order (
    .swap(order_reg[ORDER_BIT]),
    .a_idx(pl1_idx), .a_rgb(pl1_rgb),
    .b_idx(pl2_idx), .b_rgb(pl2_rgb),
    .front_vis(front_vis), .front_rgb(front_rgb),
    .back_vis(back_vis), .back_rgb(back_rgb)
  );

  lc_layer_stack #(.COLOR_W(COLOR_W), .IDX_W(IDX_W)) u_stack (
    .spr_idx(spr_idx), .spr_rgb(spr_rgb), .spr_lvl(spr_lvl),
    .front_vis(front_vis), .front_rgb(front_rgb),
    .back_vis(back_vis), .back_rgb(back_rgb),
    .bg_rgb(bg_res), .mix_rgb(mix_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst)          pix_rgb <= '0;
    else if (disp_en) pix_rgb <= mix_rgb;
    else              pix_rgb <= bg_res;
  end

  // R1
  reset_black_chk: assert property (@(posedge clk) rst |=> pix_rgb == '0);

  // R3
  top_sprite_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_en && spr_lvl == 2'b11 && spr_idx != '0) |=> pix_rgb == $past(spr_rgb));

  // R11
  blank_bg_chk: assert property (@(posedge clk) disable iff (rst)
    (!disp_en && bg_ctrl[REG_W-1:REG_W-2] == 2'b10) |=> pix_rgb == $past(bg_rgb));

  // R10
  black_bg_chk: assert property (@(posedge clk) disable iff (rst)
    (!disp_en && bg_ctrl[REG_W-1:REG_W-2] != 2'b10) |=> pix_rgb == '0);

  // R7
  pl2_front_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_en && order_reg[ORDER_BIT] && pl2_idx != '0 && spr_lvl != 2'b11)
    |=> pix_rgb == $past(pl2_rgb));

  // R7
  pl1_front_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !order_reg[ORDER_BIT] && pl1_idx != '0 && spr_lvl != 2'b11)
    |=> pix_rgb == $past(pl1_rgb));

  // R4
  hidden_sprite_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_en && spr_lvl == 2'b00 && pl1_idx == '0 && pl2_idx == '0 &&
     bg_ctrl[REG_W-1:REG_W-2] == 2'b10) |=> pix_rgb == $past(bg_rgb));
endmodule

// File: tb/layer_compositor_tb.sv
module layer_compositor_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, disp_en = 0;
  logic [1:0]  pl1_idx = 0, pl2_idx = 0, spr_idx = 0, spr_lvl = 0;
  logic [11:0] pl1_rgb = 0, pl2_rgb = 0, spr_rgb = 0, bg_rgb = 0;
  logic [7:0]  order_reg = 0, bg_ctrl = 0;
  logic [11:0] pix_rgb;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [11:0] exp; string req; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_compositor u_dut (
    .clk(clk), .rst(rst), .disp_en(disp_en),
    .pl1_idx(pl1_idx), .pl1_rgb(pl1_rgb), .pl2_idx(pl2_idx), .pl2_rgb(pl2_rgb),
    .order_reg(order_reg), .spr_idx(spr_idx), .spr_rgb(spr_rgb), .spr_lvl(spr_lvl),
    .bg_ctrl(bg_ctrl), .bg_rgb(bg_rgb), .pix_rgb(pix_rgb)
  );

  function automatic logic [11:0] model(
      logic en, logic [1:0] i1, logic [11:0] c1, logic [1:0] i2, logic [11:0] c2,
      logic [7:0] ord, logic [1:0] si, logic [11:0] sc, logic [1:0] sl,
      logic [7:0] bc, logic [11:0] bgc);
    logic [11:0] bg;
    logic fv, bv;
    logic [11:0] fc, bkc;
    bg = (bc[7:6] == 2'b10) ? bgc : 12'h000;
    if (!en) return bg;
    fv  = ord[7] ? (i2 != 0) : (i1 != 0);
    fc  = ord[7] ? c2 : c1;
    bv  = ord[7] ? (i1 != 0) : (i2 != 0);
    bkc = ord[7] ? c1 : c2;
    if (si != 0 && sl == 2'b11) return sc;
    if (fv) return fc;
    if (si != 0 && sl == 2'b10) return sc;
    if (bv) return bkc;
    if (si != 0 && sl == 2'b01) return sc;
    return bg;
  endfunction

  task automatic drive(string req, logic en, logic [1:0] i1, logic [11:0] c1,
      logic [1:0] i2, logic [11:0] c2, logic [7:0] ord, logic [1:0] si,
      logic [11:0] sc, logic [1:0] sl, logic [7:0] bc, logic [11:0] bgc,
      logic [11:0] want);
    item_t it;
    @(negedge clk);
    #1;
    disp_en = en; pl1_idx = i1; pl1_rgb = c1; pl2_idx = i2; pl2_rgb = c2;
    order_reg = ord; spr_idx = si; spr_rgb = sc; spr_lvl = sl;
    bg_ctrl = bc; bg_rgb = bgc;
    it.exp = want; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: at each falling edge, the item driven one cycle earlier is due
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (pix_rgb !== it.exp) begin
        failures++;
        $display("FAIL %s: pix_rgb=%h expected=%h", it.req, pix_rgb, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    checks++;
    if (pix_rgb !== 12'h000) begin
      failures++;
      $display("FAIL R1: pix_rgb=%h expected=000", pix_rgb);
    end
    @(negedge clk); #1 rst = 0;

    // R3: top sprite over both opaque planes
    drive("R3", 1, 2'd1, 12'h111, 2'd2, 12'h222, 8'h00, 2'd3, 12'hABC, 2'b11, 8'h80, 12'h555, 12'hABC);
    // R4: hidden sprite -> front plane, then -> background
    drive("R4", 1, 2'd1, 12'h111, 2'd2, 12'h222, 8'h00, 2'd3, 12'hABC, 2'b00, 8'h80, 12'h555, 12'h111);
    drive("R4", 1, 2'd0, 12'h111, 2'd0, 12'h222, 8'h00, 2'd3, 12'hABC, 2'b00, 8'h80, 12'h555, 12'h555);
    // R5: middle sprite under front plane, over back plane
    drive("R5", 1, 2'd1, 12'h111, 2'd2, 12'h222, 8'h00, 2'd1, 12'hDEF, 2'b10, 8'h00, 12'h555, 12'h111);
    drive("R5", 1, 2'd0, 12'h111, 2'd2, 12'h222, 8'h00, 2'd1, 12'hDEF, 2'b10, 8'h00, 12'h555, 12'hDEF);
    drive("R5", 1, 2'd1, 12'h111, 2'd0, 12'h222, 8'h80, 2'd1, 12'hDEF, 2'b10, 8'h00, 12'h555, 12'hDEF);
    // R6: bottom sprite under each plane, over background
    drive("R6", 1, 2'd0, 12'h111, 2'd3, 12'h222, 8'h00, 2'd2, 12'h777, 2'b01, 8'h80, 12'h555, 12'h222);
    drive("R6", 1, 2'd3, 12'h111, 2'd0, 12'h222, 8'h00, 2'd2, 12'h777, 2'b01, 8'h80, 12'h555, 12'h111);
    drive("R6", 1, 2'd0, 12'h111, 2'd0, 12'h222, 8'h00, 2'd2, 12'h777, 2'b01, 8'h80, 12'h555, 12'h777);
    // R7: order bit 7 picks front plane; low bits ignored
    drive("R7", 1, 2'd1, 12'h111, 2'd2, 12'h222, 8'h7F, 2'd0, 12'h000, 2'b00, 8'h00, 12'h000, 12'h111);
    drive("R7", 1, 2'd1, 12'h111, 2'd2, 12'h222, 8'h80, 2'd0, 12'h000, 2'b00, 8'h00, 12'h000, 12'h222);
    // R8: transparent plane index exposes layer beneath
    drive("R8", 1, 2'd0, 12'hF00, 2'd1, 12'h0F0, 8'h00, 2'd0, 12'h000, 2'b00, 8'h80, 12'h00F, 12'h0F0);
    // R9: transparent sprite index, even at top level
    drive("R9", 1, 2'd0, 12'h111, 2'd0, 12'h222, 8'h00, 2'd0, 12'hEEE, 2'b11, 8'hBF, 12'h345, 12'h345);
    drive("R9", 1, 2'd2, 12'h111, 2'd0, 12'h222, 8'h00, 2'd0, 12'hEEE, 2'b11, 8'hBF, 12'h345, 12'h111);
    // R10: control field other than 10 yields black
    drive("R10", 1, 2'd0, 12'h111, 2'd0, 12'h222, 8'h00, 2'd0, 12'h0, 2'b00, 8'hC0, 12'h345, 12'h000);
    drive("R10", 1, 2'd0, 12'h111, 2'd0, 12'h222, 8'h00, 2'd0, 12'h0, 2'b00, 8'h40, 12'h345, 12'h000);
    drive("R10", 1, 2'd0, 12'h111, 2'd0, 12'h222, 8'h00, 2'd0, 12'h0, 2'b00, 8'h3F, 12'h345, 12'h000);
    drive("R10", 1, 2'd0, 12'h111, 2'd0, 12'h222, 8'h00, 2'd0, 12'h0, 2'b00, 8'h9F, 12'h345, 12'h345);
    // R11: display off forces background
    drive("R11", 0, 2'd1, 12'h111, 2'd2, 12'h222, 8'h00, 2'd3, 12'hABC, 2'b11, 8'h80, 12'h678, 12'h678);
    drive("R11", 0, 2'd1, 12'h111, 2'd2, 12'h222, 8'h00, 2'd3, 12'hABC, 2'b11, 8'h00, 12'h678, 12'h000);

    // R2: pseudo-random back-to-back stream, one-cycle latency per item
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; b = lfsr;
      drive("R2", a[0] | a[1], a[3:2], a[15:4], a[17:16], a[29:18], b[7:0],
            b[9:8], b[21:10], b[23:22], {b[25:24], a[31:30], b[29:26]}, {b[31:30], a[9:0]},
            model(a[0] | a[1], a[3:2], a[15:4], a[17:16], a[29:18], b[7:0],
                  b[9:8], b[21:10], b[23:22], {b[25:24], a[31:30], b[29:26]}, {b[31:30], a[9:0]}));
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule